// File: doc/BRIEF.md
# Port Controller Alert Aggregator

This block gathers the interrupt causes of a USB Type-C port controller into one 16-bit sticky alert word and drives a single active-low interrupt line toward the host. Single-cycle event strobes from the receive path, the transmit path, the VBUS monitor and the protection logic each set one bit. The bit then holds until software writes a 1 to that position. A mask word with the same bit layout decides which pending bits may pull the interrupt line low.

Four alert positions do not hold state of their own. Each one is the OR of a secondary source: power status, fault status, extended status or extended alert. Every secondary source has its own sticky status register and its own mask register. A summary bit reads 1 while any unmasked bit of its source is pending, and software clears it by clearing that source. The three transmit outcome bits together form a transmit-complete indication. The register-access bus is outside this block: a plain write strobe with a target select and a 16-bit data word stands in for it.

Top module: `alert_agg`

## Requirements
- R1: After reset every alert and secondary status bit is 0, every mask bit of all five mask registers is 1, and `alertN` is 1.
- R2: An event strobe on a stateful alert bit sets that bit at the next clock edge, and the bit stays set until it is cleared. Stateful bits are 0, 2–8, 10–12 and 15.
- R3: A write with `wrSel`=0 clears every stateful alert bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R4: When an event strobe and a clear for the same bit arrive in the same cycle, the bit ends up set.
- R5: `alertN` is 0 exactly when the bitwise AND of the alert word and the alert mask is nonzero. The alert mask is written whole with `wrSel`=1.
- R6: Alert bit 9 (fault) reads 1 exactly while the AND of fault status and fault mask is nonzero. Fault status is cleared by writing 1s with `wrSel`=4, and fault mask is written with `wrSel`=5.
- R7: Alert bit 14 (extended alert) reads 1 exactly while the AND of the 3-bit extended alert status and its mask is nonzero. The status bits are: bit 0 sink fast role swap received, bit 1 source fast role swap sent, bit 2 timer expired. Clear is `wrSel`=8 and mask write is `wrSel`=9.
- R8: Alert bit 1 summarises power status (clear with `wrSel`=2, mask with `wrSel`=3). Alert bit 13 summarises extended status (clear with `wrSel`=6, mask with `wrSel`=7). Each follows the same masked-OR rule.
- R9: Every secondary status bit is set by its event strobe and cleared by writing a 1 to it. If both arrive in the same cycle, the set wins.
- R10: `txComplete` is 1 while any of alert bits 4 (failed), 5 (discarded) or 6 (success) is set.
- R11: Event strobes and clear writes aimed at alert bits 1, 9, 13 and 14 have no effect on those bits. Those bits follow only their sources.
- R12: A write with `wrEn` low, or with a `wrSel` value of 10 to 15, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| alertEvt | input | 16 | Event strobes for alert bits (summary positions ignored) |
| pwrEvt | input | PWR_W | Power status event strobes |
| faultEvt | input | FLT_W | Fault status event strobes |
| extEvt | input | EXT_W | Extended status event strobes |
| xAlrtEvt | input | XA_W | Extended alert event strobes |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 4 | Write target: 0 alert clear, 1 alert mask, 2/3 power, 4/5 fault, 6/7 ext status, 8/9 ext alert (clear/mask) |
| wrData | input | 16 | Write data, low bits used by narrow targets |
| alertStatus | output | 16 | Alert word including summary bits |
| pwrStatus | output | PWR_W | Power status register |
| faultStatus | output | FLT_W | Fault status register |
| extStatus | output | EXT_W | Extended status register |
| xAlrtStatus | output | XA_W | Extended alert status register |
| txComplete | output | 1 | Any transmit outcome bit pending |
| alertN | output | 1 | Interrupt line, low while an unmasked alert is pending |

## Verification
Two functions can act in the same cycle: an event strobe that sets a bit and a software write that clears that same bit. The bench produces this collision on the main alert word and on the fault source by driving the strobe together with a write-1 of the same position for one clock. It then expects the bit to read 1 afterwards, and checks that a later clear on its own removes it. A second overlap is also covered: a write that clears some bits while a strobe sets a different bit. There the bench checks that only the written positions drop.

// File: rtl/alert_agg_pkg.sv
`timescale 1ns/1ps
package alert_agg_pkg;

  localparam int ALERT_W = 16;

  // Alert positions driven by secondary sources rather than by stored state
  localparam int POS_PWR = 1;
  localparam int POS_FLT = 9;
  localparam int POS_EXT = 13;
  localparam int POS_XA  = 14;

  localparam logic [ALERT_W-1:0] SUMMARY_POS =
      (ALERT_W'(1) << POS_PWR) | (ALERT_W'(1) << POS_FLT) |
      (ALERT_W'(1) << POS_EXT) | (ALERT_W'(1) << POS_XA);

  typedef enum logic [3:0] {
    SEL_ALERT_CLR = 4'd0,
    SEL_ALERT_MSK = 4'd1,
    SEL_PWR_CLR   = 4'd2,
    SEL_PWR_MSK   = 4'd3,
    SEL_FLT_CLR   = 4'd4,
    SEL_FLT_MSK   = 4'd5,
    SEL_EXT_CLR   = 4'd6,
    SEL_EXT_MSK   = 4'd7,
    SEL_XA_CLR    = 4'd8,
    SEL_XA_MSK    = 4'd9
  } wr_sel_e;

  typedef struct packed {
    logic alertClr;
    logic alertMskWr;
    logic pwrClr;
    logic pwrMskWr;
    logic fltClr;
    logic fltMskWr;
    logic extClr;
    logic extMskWr;
    logic xaClr;
    logic xaMskWr;
  } ctl_strobe_t;

endpackage

// File: rtl/alert_ctrl.sv
`timescale 1ns/1ps
module alert_ctrl
  import alert_agg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrSel,
  output ctl_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (wrSel)
        SEL_ALERT_CLR: strobe.alertClr   = 1'b1;
        SEL_ALERT_MSK: strobe.alertMskWr = 1'b1;
        SEL_PWR_CLR:   strobe.pwrClr     = 1'b1;
        SEL_PWR_MSK:   strobe.pwrMskWr   = 1'b1;
        SEL_FLT_CLR:   strobe.fltClr     = 1'b1;
        SEL_FLT_MSK:   strobe.fltMskWr   = 1'b1;
        SEL_EXT_CLR:   strobe.extClr     = 1'b1;
        SEL_EXT_MSK:   strobe.extMskWr   = 1'b1;
        SEL_XA_CLR:    strobe.xaClr      = 1'b1;
        SEL_XA_MSK:    strobe.xaMskWr    = 1'b1;
        default:       strobe            = '0;
      endcase
    end
  end

  // R12: at most one target per write, none without a write
  a_r12_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strobe == '0));

endmodule

// File: rtl/alert_src_bank.sv
`timescale 1ns/1ps
module alert_src_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] evt,
  input  logic         clrEn,
  input  logic         mskWrEn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask,
  output logic         anyHit
);

  logic [W-1:0] clrVec;
  assign clrVec = clrEn ? wrData : '0;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          stat[b] <= 1'b0;
      else if (evt[b])    stat[b] <= 1'b1;      // set beats clear
      else if (clrVec[b]) stat[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        mask <= '1;
    else if (mskWrEn) mask <= wrData;
  end

  assign anyHit = |(stat & mask);

  // R2/R9: a strobed bit reads set on the following cycle
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stat & $past(evt)) == $past(evt)));

  // R3: a bit may only fall where a clear write named it
  a_r3_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(stat) & ~stat) & ~$past(clrVec)) == '0));

endmodule

// File: rtl/alert_datapath.sv
`timescale 1ns/1ps
module alert_datapath
  import alert_agg_pkg::*;
#(
  parameter int PWR_W = 8,
  parameter int FLT_W = 8,
  parameter int EXT_W = 1,
  parameter int XA_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_strobe_t        strobe,
  input  logic [ALERT_W-1:0] wrData,
  input  logic [ALERT_W-1:0] alertEvt,
  input  logic [PWR_W-1:0]   pwrEvt,
  input  logic [FLT_W-1:0]   faultEvt,
  input  logic [EXT_W-1:0]   extEvt,
  input  logic [XA_W-1:0]    xAlrtEvt,
  output logic [ALERT_W-1:0] alertStatus,
  output logic [PWR_W-1:0]   pwrStatus,
  output logic [FLT_W-1:0]   faultStatus,
  output logic [EXT_W-1:0]   extStatus,
  output logic [XA_W-1:0]    xAlrtStatus,
  output logic               txComplete,
  output logic               alertN
);

  logic [ALERT_W-1:0] mainStat, mainMask;
  logic [PWR_W-1:0]   pwrMask;
  logic [FLT_W-1:0]   fltMask;
  logic [EXT_W-1:0]   extMask;
  logic [XA_W-1:0]    xaMask;
  logic mainHit, pwrHit, fltHit, extHit, xaHit;
  logic [ALERT_W-1:0] summaryVec;

  alert_src_bank #(.W(ALERT_W)) u_main (
    .clk(clk), .rstN(rstN), .evt(alertEvt & ~SUMMARY_POS),
    .clrEn(strobe.alertClr), .mskWrEn(strobe.alertMskWr), .wrData(wrData),
    .stat(mainStat), .mask(mainMask), .anyHit(mainHit));

  alert_src_bank #(.W(PWR_W)) u_pwr (
    .clk(clk), .rstN(rstN), .evt(pwrEvt),
    .clrEn(strobe.pwrClr), .mskWrEn(strobe.pwrMskWr), .wrData(wrData[PWR_W-1:0]),
    .stat(pwrStatus), .mask(pwrMask), .anyHit(pwrHit));

  alert_src_bank #(.W(FLT_W)) u_flt (
    .clk(clk), .rstN(rstN), .evt(faultEvt),
    .clrEn(strobe.fltClr), .mskWrEn(strobe.fltMskWr), .wrData(wrData[FLT_W-1:0]),
    .stat(faultStatus), .mask(fltMask), .anyHit(fltHit));

  alert_src_bank #(.W(EXT_W)) u_ext (
    .clk(clk), .rstN(rstN), .evt(extEvt),
    .clrEn(strobe.extClr), .mskWrEn(strobe.extMskWr), .wrData(wrData[EXT_W-1:0]),
    .stat(extStatus), .mask(extMask), .anyHit(extHit));

  alert_src_bank #(.W(XA_W)) u_xa (
    .clk(clk), .rstN(rstN), .evt(xAlrtEvt),
    .clrEn(strobe.xaClr), .mskWrEn(strobe.xaMskWr), .wrData(wrData[XA_W-1:0]),
    .stat(xAlrtStatus), .mask(xaMask), .anyHit(xaHit));

  always_comb begin
    summaryVec          = '0;
    summaryVec[POS_PWR] = pwrHit;
    summaryVec[POS_FLT] = fltHit;
    summaryVec[POS_EXT] = extHit;
    summaryVec[POS_XA]  = xaHit;
  end

  assign alertStatus = (mainStat & ~SUMMARY_POS) | summaryVec;
  assign alertN      = ~|(alertStatus & mainMask);
  assign txComplete  = |alertStatus[6:4];

  // R5: a pending unmasked stateful bit must pull the line low
  a_r5_hit_drives_pin: assert property (@(posedge clk) disable iff (!rstN)
    mainHit |-> !alertN);
  // R5: an all-zero mask keeps the line high
  a_r5_mask_gates: assert property (@(posedge clk) disable iff (!rstN)
    (mainMask == '0) |-> alertN);
  // R6: fault summary cannot stand without a pending fault
  a_r6_fault_source: assert property (@(posedge clk) disable iff (!rstN)
    (faultStatus == '0) |-> !alertStatus[POS_FLT]);
  // R7: extended alert summary cannot stand without a pending source bit
  a_r7_xalert_source: assert property (@(posedge clk) disable iff (!rstN)
    (xAlrtStatus == '0) |-> !alertStatus[POS_XA]);
  // R11: summary positions never hold state in the main register
  a_r11_no_summary_state: assert property (@(posedge clk) disable iff (!rstN)
    (mainStat & SUMMARY_POS) == '0);
  // R10: transmit-complete requires a transmit outcome bit
  a_r10_tx_group: assert property (@(posedge clk) disable iff (!rstN)
    txComplete |-> (alertStatus[6:4] != 3'b000));

endmodule

// File: rtl/alert_agg.sv
`timescale 1ns/1ps
module alert_agg
  import alert_agg_pkg::*;
#(
  parameter int PWR_W = 8,
  parameter int FLT_W = 8,
  parameter int EXT_W = 1,
  parameter int XA_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [15:0]        alertEvt,
  input  logic [PWR_W-1:0]   pwrEvt,
  input  logic [FLT_W-1:0]   faultEvt,
  input  logic [EXT_W-1:0]   extEvt,
  input  logic [XA_W-1:0]    xAlrtEvt,
  input  logic               wrEn,
  input  logic [3:0]         wrSel,
  input  logic [15:0]        wrData,
  output logic [15:0]        alertStatus,
  output logic [PWR_W-1:0]   pwrStatus,
  output logic [FLT_W-1:0]   faultStatus,
  output logic [EXT_W-1:0]   extStatus,
  output logic [XA_W-1:0]    xAlrtStatus,
  output logic               txComplete,
  output logic               alertN
);

  ctl_strobe_t strobe;

  alert_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .strobe(strobe));

  alert_datapath #(.PWR_W(PWR_W), .FLT_W(FLT_W), .EXT_W(EXT_W), .XA_W(XA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .alertEvt(alertEvt), .pwrEvt(pwrEvt), .faultEvt(faultEvt),
    .extEvt(extEvt), .xAlrtEvt(xAlrtEvt),
    .alertStatus(alertStatus), .pwrStatus(pwrStatus), .faultStatus(faultStatus),
    .extStatus(extStatus), .xAlrtStatus(xAlrtStatus),
    .txComplete(txComplete), .alertN(alertN));

endmodule

// File: tb/alert_agg_tb_top.sv
`timescale 1ns/1ps
module alert_agg_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] alertEvt = '0;
  logic [7:0]  pwrEvt = '0;
  logic [7:0]  faultEvt = '0;
  logic [0:0]  extEvt = '0;
  logic [2:0]  xAlrtEvt = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic [15:0] alertStatus;
  logic [7:0]  pwrStatus, faultStatus;
  logic [0:0]  extStatus;
  logic [2:0]  xAlrtStatus;
  logic        txComplete, alertN;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  alert_agg dut_i (
    .clk(clk), .rstN(rstN), .alertEvt(alertEvt), .pwrEvt(pwrEvt),
    .faultEvt(faultEvt), .extEvt(extEvt), .xAlrtEvt(xAlrtEvt),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .alertStatus(alertStatus), .pwrStatus(pwrStatus), .faultStatus(faultStatus),
    .extStatus(extStatus), .xAlrtStatus(xAlrtStatus),
    .txComplete(txComplete), .alertN(alertN));

  // {evt, wrEn, wrSel, wrData, expStatus, expAlertN, expTxComplete}
  localparam int NVEC = 10;
  localparam logic [54:0] VEC [NVEC] = '{
    {16'h0001, 1'b0, 4'd0, 16'h0000, 16'h0001, 1'b0, 1'b0},
    {16'h0010, 1'b0, 4'd0, 16'h0000, 16'h0011, 1'b0, 1'b1},
    {16'h0000, 1'b1, 4'd0, 16'h0001, 16'h0010, 1'b0, 1'b1},
    {16'h0000, 1'b1, 4'd0, 16'h0000, 16'h0010, 1'b0, 1'b1},
    {16'h0000, 1'b1, 4'd1, 16'h0000, 16'h0010, 1'b1, 1'b1},
    {16'h0400, 1'b0, 4'd0, 16'h0000, 16'h0410, 1'b1, 1'b1},
    {16'h0000, 1'b1, 4'd1, 16'h0400, 16'h0410, 1'b0, 1'b1},
    {16'h0004, 1'b1, 4'd0, 16'h0410, 16'h0004, 1'b1, 1'b0},
    {16'h0000, 1'b1, 4'd0, 16'hFFFF, 16'h0000, 1'b1, 1'b0},
    {16'h0000, 1'b1, 4'd1, 16'hFFFF, 16'h0000, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, release it after the edge, leave outputs ready to sample
  task automatic cyc(input logic [15:0] ae, input logic we, input logic [3:0] sel,
                     input logic [15:0] dat, input logic [7:0] pe, input logic [7:0] fe,
                     input logic ee, input logic [2:0] xe);
    @(negedge clk);
    alertEvt = ae; wrEn = we; wrSel = sel; wrData = dat;
    pwrEvt = pe; faultEvt = fe; extEvt = ee; xAlrtEvt = xe;
    @(posedge clk);
    #2;
    alertEvt = '0; wrEn = 1'b0; wrSel = '0; wrData = '0;
    pwrEvt = '0; faultEvt = '0; extEvt = '0; xAlrtEvt = '0;
  endtask

  task automatic wr(input logic [3:0] sel, input logic [15:0] dat);
    cyc(16'h0, 1'b1, sel, dat, 8'h0, 8'h0, 1'b0, 3'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 alertStatus", 32'(alertStatus), 32'h0);
    chk("R1 alertN", 32'(alertN), 32'h1);
    chk("R1 secondary", {pwrStatus, faultStatus, 5'(extStatus), 8'(xAlrtStatus)}, 32'h0);

    // Table walk: R2 R3 R5 R10
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][54:39], VEC[i][38], VEC[i][37:34], VEC[i][33:18],
          8'h0, 8'h0, 1'b0, 3'h0);
      chk($sformatf("R2/R3 vec%0d status", i), 32'(alertStatus), 32'(VEC[i][17:2]));
      chk($sformatf("R5 vec%0d alertN", i), 32'(alertN), 32'(VEC[i][1]));
      chk($sformatf("R10 vec%0d txComplete", i), 32'(txComplete), 32'(VEC[i][0]));
    end

    // R1: mask reset value 1 shown on power mask (no mask write issued so far)
    cyc(16'h0, 1'b0, 4'd0, 16'h0, 8'h80, 8'h0, 1'b0, 3'h0);
    chk("R1 pwr mask default", 32'(alertStatus), 32'h0002);
    chk("R8 power summary", 32'(alertN), 32'h0);
    cyc(16'h0, 1'b0, 4'd0, 16'h0, 8'h0, 8'h0, 1'b1, 3'h0);
    chk("R8 ext status summary", 32'(alertStatus), 32'h2002);
    wr(4'd3, 16'h007F);
    chk("R8 power mask gates", 32'(alertStatus), 32'h2000);
    wr(4'd7, 16'h0000);
    chk("R8 ext mask gates", 32'({alertStatus, 15'h0, alertN}), {16'h0000, 16'h0001});
    wr(4'd2, 16'h0080);
    wr(4'd6, 16'h0001);
    chk("R9 secondary cleared", 32'({pwrStatus, 7'h0, extStatus}), 32'h0);
    wr(4'd3, 16'h00FF);
    wr(4'd7, 16'h0001);

    // R4 set wins against clear, main register
    cyc(16'h0020, 1'b1, 4'd0, 16'h0020, 8'h0, 8'h0, 1'b0, 3'h0);
    chk("R4 set beats clear", 32'(alertStatus), 32'h0020);
    chk("R10 discarded completes", 32'(txComplete), 32'h1);
    wr(4'd0, 16'h0020);
    chk("R3 clear after collision", 32'(alertStatus), 32'h0);

    // R6 fault summary and R11 summary immunity
    cyc(16'h0, 1'b0, 4'd0, 16'h0, 8'h0, 8'h08, 1'b0, 3'h0);
    chk("R6 fault sets bit9", 32'(alertStatus), 32'h0200);
    chk("R6 fault pin", 32'(alertN), 32'h0);
    wr(4'd5, 16'h0000);
    chk("R6 fault masked", 32'({alertStatus, 8'h0, faultStatus}), {16'h0000, 16'h0008});
    wr(4'd5, 16'h00FF);
    wr(4'd0, 16'hFFFF);
    chk("R11 clear write ignores bit9", 32'(alertStatus), 32'h0200);
    wr(4'd4, 16'h0008);
    chk("R6 fault source cleared", 32'({alertStatus, 15'h0, alertN}), 32'h0000_0001);

    // R9 set wins on a secondary source
    cyc(16'h0, 1'b1, 4'd4, 16'h0001, 8'h0, 8'h01, 1'b0, 3'h0);
    chk("R9 fault set beats clear", 32'(faultStatus), 32'h01);
    wr(4'd4, 16'h0001);
    chk("R9 fault clear", 32'(faultStatus), 32'h00);

    // R7 extended alert summary (bit2 = timer expired)
    cyc(16'h0, 1'b0, 4'd0, 16'h0, 8'h0, 8'h0, 1'b0, 3'b100);
    chk("R7 xalert sets bit14", 32'(alertStatus), 32'h4000);
    wr(4'd9, 16'h0003);
    chk("R7 xalert masked", 32'({alertStatus, 13'h0, xAlrtStatus}), {16'h0000, 16'h0004});
    wr(4'd9, 16'h0007);
    chk("R7 xalert unmasked", 32'(alertStatus), 32'h4000);
    wr(4'd8, 16'h0004);
    chk("R7 xalert cleared", 32'(alertStatus), 32'h0);

    // R11 strobes on summary positions ignored
    cyc(16'h6202, 1'b0, 4'd0, 16'h0, 8'h0, 8'h0, 1'b0, 3'h0);
    chk("R11 summary strobes ignored", 32'({alertStatus, 15'h0, alertN}), 32'h0000_0001);

    // R12 unused select and idle write strobe
    cyc(16'h8001, 1'b0, 4'd0, 16'h0, 8'h0, 8'h0, 1'b0, 3'h0);
    wr(4'd15, 16'hFFFF);
    chk("R12 unused code", 32'(alertStatus), 32'h8001);
    cyc(16'h0, 1'b0, 4'd0, 16'hFFFF, 8'h0, 8'h0, 1'b0, 3'h0);
    chk("R12 wrEn low", 32'(alertStatus), 32'h8001);
    cyc(16'h0, 1'b0, 4'd1, 16'h0000, 8'h0, 8'h0, 1'b0, 3'h0);
    chk("R12 mask untouched", 32'(alertN), 32'h0);
    wr(4'd0, 16'h8000);
    chk("R3 partial clear", 32'(alertStatus), 32'h0001);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule